// File: doc/BRIEF.md
# Dual-Clock Sample Capture Buffer

This block collects one fixed-size batch of samples that arrive on a fast sampling clock and stores them in a dual-port memory. It then offers the batch, entry by entry, to a consumer that runs on a separate and slower clock, such as a serial transmitter. The write side and the read side each own their memory port and their address counter. The only things that pass between the two clock domains are two toggle flags, each resynchronised by a chain of flip-flops.

The write side starts armed at address zero. It stores one sample on each strobe. After the last entry is stored it passes through a short end-of-batch step, which drops the write enable, clears the address and flips the "batch ready" toggle. It then waits in a handoff state. The read side sees the toggle change, clears its empty flag and returns one entry for each read request, in order. When the last entry has been fetched it sets empty again and flips a "batch consumed" toggle. That toggle re-arms the write side for the next batch.

Top module: `capture_xfer_buf`

## Requirements
- R1: After reset, `rd_empty` is 1, `rd_valid` is 0, and the write side is armed so that the next strobe stores its sample at address 0.
- R2: While capture is armed, each cycle with `smp_stb` high stores `smp_data` at the current write address, and the address then advances by one. Cycles without a strobe store nothing.
- R3: A batch holds exactly DEPTH entries (default 100). Strobes after the DEPTH-th stored sample are ignored until the read side has consumed the batch.
- R4: Once a batch is complete, `rd_empty` falls in the read clock domain, after the ready indication has passed through the synchroniser stages.
- R5: Each `rd_req` sampled while `rd_empty` is 0 fetches the next entry, starting at address 0. `rd_data` carries that entry and `rd_valid` is 1 on the read clock edge that follows the request.
- R6: `rd_empty` rises on the same read clock edge that fetches entry DEPTH-1, so `rd_valid` for the last entry and `rd_empty` appear together. A `rd_req` while `rd_empty` is 1 produces no `rd_valid`.
- R7: After a batch has been read out, capture re-arms and the next batch is stored from address 0 again.
- R8: Strobes that arrive while a complete batch waits for readout, or while it is being read, leave the stored entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Fast sampling clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| smp_data | input | DATA_W | Sample value |
| smp_stb | input | 1 | Sample strobe, one sample per high cycle |
| rclk | input | 1 | Slower readout clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| rd_req | input | 1 | Request the next stored entry |
| rd_data | output | DATA_W | Entry fetched by the previous request |
| rd_valid | output | 1 | `rd_data` holds a newly fetched entry |
| rd_empty | output | 1 | No unread entry is available |

## Verification
The first batch is driven with five strobes more than DEPTH. A design that does not stop at the limit would wrap around and overwrite entries 0 to 4, and the readback would show the extra values there. While the batch waits for readout, a full batch of marker values is strobed in. A design that keeps writing during handoff would return those markers instead of the captured data. The bench checks `rd_empty` around the last entry, so a flag that rises one fetch early or one fetch late is caught, and it checks that requests made while empty produce no valid pulse. The second batch uses strobes with idle cycles between them and is read with back-to-back requests. This exposes an address counter that advances without a strobe, or a write side that never re-arms.

// File: rtl/cxb_pkg.sv
`timescale 1ns/1ps
package cxb_pkg;
  typedef enum logic [1:0] {
    WS_CAPTURE = 2'd0,
    WS_EOC     = 2'd1,
    WS_HANDOFF = 2'd2
  } wr_state_e;
endpackage

// File: rtl/cxb_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchroniser for a toggle flag.
module cxb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cxb_ram.sv
`timescale 1ns/1ps
// Simple dual-port, dual-clock memory with registered read.
module cxb_ram #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 100,
  parameter int AW     = 7
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cxb_wr_ctrl.sv
`timescale 1ns/1ps
// Write-domain sequencer: capture, end of batch, handoff.
module cxb_wr_ctrl
  import cxb_pkg::*;
#(
  parameter int DEPTH = 100,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  input  logic          done_tgl_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          full_tgl
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  wr_state_e state;
  logic      done_seen;

  assign we = (state == WS_CAPTURE) && stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= WS_CAPTURE;
      waddr     <= '0;
      full_tgl  <= 1'b0;
      done_seen <= 1'b0;
    end else begin
      unique case (state)
        WS_CAPTURE: begin
          if (stb) begin
            waddr <= waddr + AW'(1);
            if (waddr == LAST) state <= WS_EOC;
          end
        end
        WS_EOC: begin
          waddr    <= '0;
          full_tgl <= ~full_tgl;
          state    <= WS_HANDOFF;
        end
        WS_HANDOFF: begin
          if (done_tgl_s != done_seen) begin
            done_seen <= done_tgl_s;
            state     <= WS_CAPTURE;
          end
        end
        default: state <= WS_CAPTURE;
      endcase
    end
  end
endmodule

// File: rtl/cxb_rd_ctrl.sv
`timescale 1ns/1ps
// Read-domain sequencer: wait for a batch, hand out entries in order.
module cxb_rd_ctrl #(
  parameter int DEPTH = 100,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          full_tgl_s,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic          empty,
  output logic          valid,
  output logic          done_tgl
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic full_seen;

  assign re = req && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      empty     <= 1'b1;
      raddr     <= '0;
      valid     <= 1'b0;
      done_tgl  <= 1'b0;
      full_seen <= 1'b0;
    end else begin
      valid <= re;
      if (empty) begin
        if (full_tgl_s != full_seen) begin
          full_seen <= full_tgl_s;
          empty     <= 1'b0;
          raddr     <= '0;
        end
      end else if (req) begin
        if (raddr == LAST) begin
          raddr    <= '0;
          empty    <= 1'b1;
          done_tgl <= ~done_tgl;
        end else begin
          raddr <= raddr + AW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/capture_xfer_buf.sv
`timescale 1ns/1ps
// Top: batch capture on wclk, ordered readout on rclk.
module capture_xfer_buf #(
  parameter int DATA_W      = 12,
  parameter int DEPTH       = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_stb,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH + 1) : 1;

  logic          wr_en;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic          rd_en;
  logic          full_tgl, full_tgl_s;
  logic          done_tgl, done_tgl_s;

  cxb_wr_ctrl #(.DEPTH(DEPTH), .AW(AW)) i_wr (
    .clk(wclk), .rst(wrst), .stb(smp_stb), .done_tgl_s(done_tgl_s),
    .we(wr_en), .waddr(waddr), .full_tgl(full_tgl)
  );

  cxb_sync #(.STAGES(SYNC_STAGES)) i_sync_full (
    .clk(rclk), .rst(rrst), .d(full_tgl), .q(full_tgl_s)
  );

  cxb_sync #(.STAGES(SYNC_STAGES)) i_sync_done (
    .clk(wclk), .rst(wrst), .d(done_tgl), .q(done_tgl_s)
  );

  cxb_rd_ctrl #(.DEPTH(DEPTH), .AW(AW)) i_rd (
    .clk(rclk), .rst(rrst), .req(rd_req), .full_tgl_s(full_tgl_s),
    .re(rd_en), .raddr(raddr), .empty(rd_empty), .valid(rd_valid),
    .done_tgl(done_tgl)
  );

  cxb_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) i_ram (
    .wclk(wclk), .we(wr_en), .waddr(waddr), .wdata(smp_data),
    .rclk(rclk), .re(rd_en), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: rtl/cxb_checker.sv
`timescale 1ns/1ps
module cxb_checker #(
  parameter int DEPTH = 100,
  parameter int AW    = 7
) (
  input logic          wclk,
  input logic          wrst,
  input logic          rclk,
  input logic          rrst,
  input logic          smp_stb,
  input logic          wr_en,
  input logic [AW-1:0] waddr,
  input logic          rd_req,
  input logic          rd_valid,
  input logic          rd_empty,
  input logic [AW-1:0] raddr
);
  AST_WRITE_NEEDS_STROBE: assert property (@(posedge wclk) disable iff (wrst)
    wr_en |-> smp_stb); // R2
  AST_WRITE_ADDR_STEP: assert property (@(posedge wclk) disable iff (wrst)
    wr_en |=> (waddr == $past(waddr) + AW'(1))); // R2
  AST_WRITE_IN_BATCH: assert property (@(posedge wclk) disable iff (wrst)
    wr_en |-> (waddr < AW'(DEPTH))); // R3
  AST_VALID_FOLLOWS_REQ: assert property (@(posedge rclk) disable iff (rrst)
    rd_valid |-> ($past(rd_req) && !$past(rd_empty))); // R5
  AST_READ_ADDR_RANGE: assert property (@(posedge rclk) disable iff (rrst)
    raddr < AW'(DEPTH)); // R5
  AST_EMPTY_NO_VALID: assert property (@(posedge rclk) disable iff (rrst)
    rd_empty |=> !rd_valid); // R6
endmodule

bind capture_xfer_buf cxb_checker #(.DEPTH(DEPTH), .AW(AW)) i_cxb_checker (
  .wclk(wclk), .wrst(wrst), .rclk(rclk), .rrst(rrst),
  .smp_stb(smp_stb), .wr_en(wr_en), .waddr(waddr),
  .rd_req(rd_req), .rd_valid(rd_valid), .rd_empty(rd_empty), .raddr(raddr)
);

// File: tb/test_capture_xfer_buf.sv
`timescale 1ns/1ps
module test_capture_xfer_buf;
  localparam int DW    = 12;
  localparam int DEPTH = 100;

  logic          wclk = 0, rclk = 0;
  logic          wrst = 1, rrst = 1;
  logic [DW-1:0] smp_data = '0;
  logic          smp_stb = 0;
  logic          rd_req = 0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, rd_empty;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4  wclk = ~wclk;   // 125 MHz
  always #11 rclk = ~rclk;   // slower read clock

  capture_xfer_buf #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(2)) i_capture_xfer_buf (
    .wclk(wclk), .wrst(wrst), .smp_data(smp_data), .smp_stb(smp_stb),
    .rclk(rclk), .rrst(rrst), .rd_req(rd_req),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_empty(rd_empty)
  );

  function automatic logic [DW-1:0] val_a(int i); return DW'(i * 7 + 3);     endfunction
  function automatic logic [DW-1:0] val_b(int i); return DW'(4000 - i * 13); endfunction
  function automatic logic [DW-1:0] val_j(int i); return DW'(12'hA00 + i);   endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge rclk);
    chk(rd_empty == 1'b1, "R1 empty after reset", int'(rd_empty), 1);
    chk(rd_valid == 1'b0, "R1 valid after reset", int'(rd_valid), 0);
  endtask

  task automatic t_req_while_empty(string tag);
    @(negedge rclk); rd_req = 1;
    @(negedge rclk); rd_req = 0;
    chk(rd_valid == 1'b0, tag, int'(rd_valid), 0);
    chk(rd_empty == 1'b1, tag, int'(rd_empty), 1);
  endtask

  // which: 0 = batch A, 1 = batch B, 2 = marker values
  task automatic t_fill(int which, int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      smp_stb  = 1;
      smp_data = (which == 0) ? val_a(i) : (which == 1) ? val_b(i) : val_j(i);
      if (gaps) begin
        @(negedge wclk); smp_stb = 0;
      end
    end
    @(negedge wclk); smp_stb = 0;
  endtask

  task automatic t_wait_ready(string tag);
    int n = 0;
    while (rd_empty && n < 200) begin @(negedge rclk); n++; end
    chk(rd_empty == 1'b0, tag, int'(rd_empty), 0);
  endtask

  task automatic t_read_batch(int which, bit back_to_back);
    logic [DW-1:0] e;
    if (back_to_back) begin @(negedge rclk); rd_req = 1; end
    for (int i = 0; i < DEPTH; i++) begin
      e = (which == 0) ? val_a(i) : val_b(i);
      if (back_to_back) begin
        @(negedge rclk);
        if (i == DEPTH - 1) rd_req = 0;
      end else begin
        @(negedge rclk); rd_req = 1;
        @(negedge rclk); rd_req = 0;
      end
      chk(rd_valid == 1'b1, "R5 valid after request", int'(rd_valid), 1);
      chk(rd_data == e, (which == 0) ? "R5 R3 R8 data of batch A" : "R7 R2 data of batch B",
          int'(rd_data), int'(e));
      chk(rd_empty == (i == DEPTH - 1), "R6 empty timing", int'(rd_empty),
          int'(i == DEPTH - 1));
    end
  endtask

  initial begin
    repeat (4) @(negedge wclk);
    wrst = 0; rrst = 0;
    t_reset_state();
    t_req_while_empty("R6 request ignored after reset");
    t_fill(0, DEPTH + 5, 1'b0);          // R3: 5 extra strobes
    t_wait_ready("R4 batch A ready");
    t_fill(2, DEPTH, 1'b0);              // R8: markers during handoff
    t_read_batch(0, 1'b0);
    t_req_while_empty("R6 request ignored after readout");
    repeat (30) @(negedge wclk);
    t_fill(1, DEPTH, 1'b1);              // R7, R2 with gaps
    t_wait_ready("R4 batch B ready");
    t_read_batch(1, 1'b1);
    t_req_while_empty("R6 request ignored at end");
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge wclk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule